// File: doc/BRIEF.md
# Dual-Length Galois LFSR with Entropy Mixer

This block is a pseudo-random bit generator built around a Galois (internal XOR) shift register. At run time it works either as a 59-bit or as a 128-bit register. The register is seeded in one of two ways. Software can supply a seed as a sequence of 16-bit words. Otherwise the block gathers the seed one bit at a time from an external entropy bit stream that arrives with a valid strobe.

Once seeded, and while `go` is high, the block produces one random bit per step. An output mux sets how the register bits and the entropy bits combine:

- the register alone;
- the register XORed with entropy;
- alternating samples of register and entropy;
- alternating samples with an even-parity bit after every eight data bits;
- entropy alone.

A step waits for a valid entropy bit whenever the selected mode actually uses entropy. A user-supplied seed means the entropy stream adds nothing to the register stream. In that case the XOR and alternating modes fall back to the register stream and do not wait for entropy.

Top module: `dual_lfsr_mixer`

## Requirements
- R1: `len_sel`=1 selects a 128-bit register and `len_sel`=0 a 59-bit register whose bits above 58 stay zero. Each advance shifts right: the emitted bit is bit 0, and when that bit is 1 the shifted state is XORed with the tap mask. The mask is bits {127,28,26,1} for 128 bits and bits {58,21,20,0} for 59 bits.
- R2: With `seed_src`=1, each `seed_we` pulse stores `seed_word` as word k of the seed, bits 16k+15:16k. Word k counts up from 0. The write that completes the seed loads the register in that same clock edge, and `seeded` is high from the next cycle. The 59-bit seed needs 4 writes and bits 63:59 are dropped. The 128-bit seed needs 8 writes.
- R3: The word pointer returns to 0 after reset, after each completed seed, and when `len_sel` or `seed_src` changes. A partial seed never loads. Seed writes made while `seed_src`=0 have no effect.
- R4: With `seed_src`=0 and `seeded` low, the k-th valid entropy bit (counting from 0) becomes seed bit k. The register loads on the 59th or 128th bit.
- R5: A seed that is all zero after masking is loaded as the value 1.
- R6: A step occurs in a cycle where `go` and `seeded` are high and, if the mode needs entropy, `ent_valid` is high. `rnd_valid` and `rnd_bit` show the result one cycle later. The first bit after a load is seed bit 0. After reset, `seeded` and `rnd_valid` are low.
- R7: `out_mode` encodings are 0 register only, 1 register XOR entropy, and 4 entropy only. The values 5 to 7 behave as 0. The register advances on every data step.
- R8: Mode 2 alternates register and entropy bits, starting with a register bit after `go` rises or after a load.
- R9: Mode 3 emits eight alternating data bits and then one bit that makes the nine even in parity. The register holds during the parity bit.
- R10: With `seed_src`=1, modes 1 and 2 give the same stream as mode 0 and need no entropy. Mode 3 then uses register bits for its data bits.
- R11: A change of `len_sel` or `seed_src` clears `seeded` and produces no step in that cycle. With `go` low there is no output, and the alternation and parity counts restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_sel | input | 1 | 1: 128-bit register, 0: 59-bit register |
| seed_src | input | 1 | 1: user words, 0: entropy stream |
| out_mode | input | 3 | Output combination mode |
| seed_we | input | 1 | User seed word write strobe |
| seed_word | input | 16 | User seed word |
| ent_bit | input | 1 | Entropy bit |
| ent_valid | input | 1 | Entropy bit valid |
| go | input | 1 | Enables stepping |
| rnd_bit | output | 1 | Random output bit |
| rnd_valid | output | 1 | `rnd_bit` is new this cycle |
| seeded | output | 1 | Register holds a loaded seed |

## Verification
The assertions assume that `out_mode` changes only while `go` is low. They also assume that a length or source change is followed by a fresh seed before stepping resumes. Under those conditions the alternation and parity counters and the upper zero bits of the short register stay meaningful.

The stimulus respects this. It lowers `go` between runs and changes modes only in those gaps. Every change of length or source is followed by a complete seed sequence, except in the one scenario that deliberately changes configuration under `go` to observe the drop of `seeded`.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

  typedef enum logic [2:0] {
    OM_LFSR   = 3'd0,
    OM_XOR    = 3'd1,
    OM_CYC    = 3'd2,
    OM_CYCPAR = 3'd3,
    OM_ENT    = 3'd4
  } out_mode_e;

  localparam int unsigned DLM_LONG_W  = 128;
  localparam int unsigned DLM_SHORT_W = 59;
  localparam int unsigned DLM_WORD_W  = 16;
  localparam int unsigned DLM_GROUP   = 8;
  localparam logic [127:0] DLM_LONG_TAPS  = 128'h8000_0000_0000_0000_0000_0000_1400_0002;
  localparam logic [127:0] DLM_SHORT_TAPS = 128'h0000_0000_0000_0000_0400_0000_0030_0001;

  // Does the mode consume entropy for a step?
  function automatic logic needs_entropy(input logic [2:0] m, input logic user);
    case (m)
      OM_ENT:                  return 1'b1;
      OM_XOR, OM_CYC, OM_CYCPAR: return !user;
      default:                 return 1'b0;
    endcase
  endfunction

  // Data bit chosen for one step.
  function automatic logic pick_bit(input logic [2:0] m, input logic user,
                                    input logic phase, input logic lb, input logic eb);
    case (m)
      OM_XOR:            return user ? lb : (lb ^ eb);
      OM_CYC, OM_CYCPAR: return (user || !phase) ? lb : eb;
      OM_ENT:            return eb;
      default:           return lb;
    endcase
  endfunction

endpackage

// File: rtl/dlm_seed_loader.sv
module dlm_seed_loader #(
  parameter int unsigned LONG_W  = 128,
  parameter int unsigned SHORT_W = 59,
  parameter int unsigned WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_sel,
  input  logic              seed_src,
  input  logic              cfg_chg,
  input  logic              seeded,
  input  logic              seed_we,
  input  logic [WORD_W-1:0] seed_word,
  input  logic              ent_bit,
  input  logic              ent_valid,
  output logic              load,
  output logic [LONG_W-1:0] load_val
);
  localparam int unsigned LWORDS = LONG_W / WORD_W;
  localparam int unsigned SWORDS = (SHORT_W + WORD_W - 1) / WORD_W;
  localparam int unsigned PW     = $clog2(LWORDS);
  localparam int unsigned CW     = $clog2(LONG_W);

  logic [WORD_W-1:0] words_q [LWORDS];
  logic [PW-1:0]     ptr_q;
  logic [CW-1:0]     ecnt_q;
  logic [LONG_W-1:0] ebuf_q;

  logic [PW-1:0]     last_ptr;
  logic [CW-1:0]     last_bit;
  logic              user_wr, ent_take, user_done, ent_done;
  logic [LONG_W-1:0] user_img, ent_img, len_mask, raw;

  assign last_ptr  = len_sel ? PW'(LWORDS - 1) : PW'(SWORDS - 1);
  assign last_bit  = len_sel ? CW'(LONG_W - 1) : CW'(SHORT_W - 1);
  assign user_wr   = seed_we & seed_src & ~cfg_chg;
  assign ent_take  = ~seed_src & ~seeded & ent_valid & ~cfg_chg;
  assign user_done = user_wr & (ptr_q == last_ptr);
  assign ent_done  = ent_take & (ecnt_q == last_bit);

  // Seed images including the word or bit arriving this cycle.
  for (genvar g = 0; g < LWORDS; g++) begin : g_word
    assign user_img[g*WORD_W +: WORD_W] = (PW'(g) == ptr_q) ? seed_word : words_q[g];
  end
  for (genvar b = 0; b < LONG_W; b++) begin : g_bit
    assign ent_img[b] = (CW'(b) == ecnt_q) ? ent_bit : ebuf_q[b];
  end

  assign len_mask = len_sel ? {LONG_W{1'b1}}
                            : {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
  assign raw      = (seed_src ? user_img : ent_img) & len_mask;
  assign load_val = (raw == '0) ? LONG_W'(1) : raw;
  assign load     = user_done | ent_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ecnt_q <= '0;
      ebuf_q <= '0;
      for (int i = 0; i < LWORDS; i++) words_q[i] <= '0;
    end else if (cfg_chg) begin
      ptr_q  <= '0;
      ecnt_q <= '0;
    end else begin
      if (user_wr) begin
        words_q[ptr_q] <= seed_word;
        ptr_q          <= user_done ? '0 : ptr_q + PW'(1);
      end
      if (ent_take) begin
        ebuf_q[ecnt_q] <= ent_bit;
        ecnt_q         <= ent_done ? '0 : ecnt_q + CW'(1);
      end
    end
  end

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> ptr_q <= last_ptr);
  // R4
  ecnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> ecnt_q <= last_bit);

endmodule

// File: rtl/dlm_galois_lfsr.sv
module dlm_galois_lfsr #(
  parameter int unsigned       LONG_W     = 128,
  parameter int unsigned       SHORT_W    = 59,
  parameter logic [LONG_W-1:0] LONG_TAPS  = dlm_pkg::DLM_LONG_TAPS,
  parameter logic [LONG_W-1:0] SHORT_TAPS = dlm_pkg::DLM_SHORT_TAPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_sel,
  input  logic              load,
  input  logic [LONG_W-1:0] load_val,
  input  logic              adv,
  output logic              out_bit
);
  logic [LONG_W-1:0] state_q;

  function automatic logic [LONG_W-1:0] gal_step(input logic [LONG_W-1:0] s,
                                                 input logic long_len);
    logic [LONG_W-1:0] m;
    m = long_len ? LONG_TAPS : SHORT_TAPS;
    return (s >> 1) ^ (s[0] ? m : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= '0;
    else if (load)    state_q <= load_val;
    else if (adv)     state_q <= gal_step(state_q, len_sel);
  end

  assign out_bit = state_q[0];

  // R5
  nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load || adv) |=> state_q != '0);
  // R1
  short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((load || adv) && !len_sel) |=> state_q[LONG_W-1:SHORT_W] == '0);

endmodule

// File: rtl/dlm_out_combiner.sv
module dlm_out_combiner #(
  parameter int unsigned GROUP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       load,
  input  logic       step,
  input  logic [2:0] mode,
  input  logic       src_user,
  input  logic       lfsr_bit,
  input  logic       ent_bit,
  output logic       adv,
  output logic       rnd_bit,
  output logic       rnd_valid
);
  import dlm_pkg::*;
  localparam int unsigned CNT_W = $clog2(GROUP + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q, par_q;
  logic             par_mode, par_slot, data_bit;

  assign par_mode = (mode == OM_CYCPAR);
  assign par_slot = par_mode && (cnt_q == CNT_W'(GROUP));
  assign data_bit = pick_bit(mode, src_user, phase_q, lfsr_bit, ent_bit);
  assign adv      = step & ~par_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd_valid <= 1'b0;
      rnd_bit   <= 1'b0;
    end else begin
      rnd_valid <= step;
      if (step) rnd_bit <= par_slot ? par_q : data_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      par_q   <= 1'b0;
    end else if (!go || load) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      par_q   <= 1'b0;
    end else if (step) begin
      if (par_slot) begin
        cnt_q <= '0;
        par_q <= 1'b0;
      end else begin
        phase_q <= ~phase_q;
        if (par_mode) begin
          cnt_q <= cnt_q + CNT_W'(1);
          par_q <= par_q ^ data_bit;
        end
      end
    end
  end

  // R9
  grp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(GROUP));
  // R6
  step_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> rnd_valid);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !rnd_valid);

endmodule

// File: rtl/dual_lfsr_mixer.sv
module dual_lfsr_mixer #(
  parameter int unsigned       LONG_W     = dlm_pkg::DLM_LONG_W,
  parameter int unsigned       SHORT_W    = dlm_pkg::DLM_SHORT_W,
  parameter int unsigned       WORD_W     = dlm_pkg::DLM_WORD_W,
  parameter int unsigned       GROUP      = dlm_pkg::DLM_GROUP,
  parameter logic [LONG_W-1:0] LONG_TAPS  = dlm_pkg::DLM_LONG_TAPS,
  parameter logic [LONG_W-1:0] SHORT_TAPS = dlm_pkg::DLM_SHORT_TAPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_sel,
  input  logic              seed_src,
  input  logic [2:0]        out_mode,
  input  logic              seed_we,
  input  logic [WORD_W-1:0] seed_word,
  input  logic              ent_bit,
  input  logic              ent_valid,
  input  logic              go,
  output logic              rnd_bit,
  output logic              rnd_valid,
  output logic              seeded
);
  import dlm_pkg::*;

  logic              len_q, src_q, seeded_q;
  logic              cfg_chg, load, adv, lfsr_bit, step, ent_ok;
  logic [LONG_W-1:0] load_val;

  assign cfg_chg = (len_sel != len_q) | (seed_src != src_q);
  assign ent_ok  = ~needs_entropy(out_mode, seed_src) | ent_valid;
  assign step    = go & seeded_q & ~cfg_chg & ~load & ent_ok;
  assign seeded  = seeded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= 1'b0;
      src_q    <= 1'b0;
      seeded_q <= 1'b0;
    end else begin
      len_q <= len_sel;
      src_q <= seed_src;
      if (cfg_chg)   seeded_q <= 1'b0;
      else if (load) seeded_q <= 1'b1;
    end
  end

  dlm_seed_loader #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .WORD_W(WORD_W)) u_seed (
    .clk, .rst_n, .len_sel, .seed_src, .cfg_chg, .seeded(seeded_q),
    .seed_we, .seed_word, .ent_bit, .ent_valid, .load, .load_val
  );

  dlm_galois_lfsr #(.LONG_W(LONG_W), .SHORT_W(SHORT_W),
                    .LONG_TAPS(LONG_TAPS), .SHORT_TAPS(SHORT_TAPS)) u_lfsr (
    .clk, .rst_n, .len_sel, .load, .load_val, .adv, .out_bit(lfsr_bit)
  );

  dlm_out_combiner #(.GROUP(GROUP)) u_comb (
    .clk, .rst_n, .go, .load, .step, .mode(out_mode), .src_user(seed_src),
    .lfsr_bit, .ent_bit, .adv, .rnd_bit, .rnd_valid
  );

  // R11
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !rnd_valid);
  // R2
  load_seeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cfg_chg) |=> seeded);

endmodule

// File: tb/dual_lfsr_mixer_bench.sv
module dual_lfsr_mixer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [127:0] MASK_L = 128'h8000_0000_0000_0000_0000_0000_1400_0002;
  localparam logic [127:0] MASK_S = 128'h0400_0000_0030_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic len_sel = 1'b1, seed_src = 1'b1, seed_we = 1'b0, ent_bit = 1'b0, ent_valid = 1'b0, go = 1'b0;
  logic [2:0]  out_mode = 3'd0;
  logic [15:0] seed_word = '0;
  logic rnd_bit, rnd_valid, seeded;

  int checks = 0, errors = 0;
  logic [127:0] ms;
  logic [15:0]  sw [8];
  bit cap [512];
  bit refb [512];
  int ncap, nref;

  always #2.5 clk = ~clk;

  dual_lfsr_mixer u_dual_lfsr_mixer (
    .clk, .rst_n, .len_sel, .seed_src, .out_mode, .seed_we, .seed_word,
    .ent_bit, .ent_valid, .go, .rnd_bit, .rnd_valid, .seeded
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] m_adv(input logic [127:0] s, input bit long_len);
    logic [127:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ (long_len ? MASK_L : MASK_S);
    return n;
  endfunction

  function automatic logic [127:0] m_fix(input logic [127:0] s, input bit long_len);
    logic [127:0] r;
    r = long_len ? s : (s & ((128'd1 << 59) - 128'd1));
    return (r == '0) ? 128'd1 : r;
  endfunction

  // Writes nw words from sw; fresh: seeded expected low before last edge (R3).
  task automatic load_user(input int nw, input bit fresh, input string tag);
    logic [127:0] img;
    img = '0;
    for (int k = 0; k < nw; k++) begin
      @(negedge clk);
      if (fresh && k == nw - 1) chk(seeded === 1'b0, "R3 partial seed", seeded, 0);
      seed_we = 1'b1; seed_word = sw[k];
      img[k*16 +: 16] = sw[k];
    end
    @(negedge clk);
    seed_we = 1'b0;
    chk(seeded === 1'b1, tag, seeded, 1);
    ms = m_fix(img, len_sel);
  endtask

  task automatic feed_entropy(input int nbits);
    logic [127:0] img;
    img = '0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      if (k % 5 == 4) begin
        ent_valid = 1'b0;
        @(negedge clk);
      end
      if (k == nbits - 1) chk(seeded === 1'b0, "R4 before last bit", seeded, 0);
      ent_valid = 1'b1;
      ent_bit = 1'($urandom);
      img[k] = ent_bit;
    end
    @(negedge clk);
    ent_valid = 1'b0;
    chk(seeded === 1'b1, "R4 entropy seed loaded", seeded, 1);
    ms = m_fix(img, len_sel);
  endtask

  task automatic run(input int n, input logic [2:0] mode, input int gap_pct, input string tag);
    bit pend, expb, need, ev, eb, user, d;
    int cnt;
    bit phase, par;
    pend = 0; cnt = 0; phase = 0; par = 0; ncap = 0;
    user = seed_src;
    need = (mode == 3'd4) || (!user && (mode == 3'd1 || mode == 3'd2 || mode == 3'd3));
    out_mode = mode;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (pend) begin
        chk(rnd_valid === 1'b1 && rnd_bit === expb, tag, {rnd_valid, rnd_bit}, {1'b1, expb});
        if (ncap < 512) begin cap[ncap] = rnd_bit; ncap++; end
      end else begin
        chk(rnd_valid === 1'b0, {tag, " R6 no step"}, rnd_valid, 0);
      end
      if (i == n) break;
      ev = ($urandom % 100) >= gap_pct;
      eb = 1'($urandom);
      ent_valid = ev; ent_bit = eb; go = 1'b1;
      pend = !need || ev;
      if (pend) begin
        if (mode == 3'd3 && cnt == 8) begin
          expb = par; cnt = 0; par = 0;
        end else begin
          case (mode)
            3'd1: d = user ? ms[0] : ms[0] ^ eb;
            3'd2, 3'd3: d = (user || !phase) ? ms[0] : eb;
            3'd4: d = eb;
            default: d = ms[0];
          endcase
          ms = m_adv(ms, len_sel);
          phase = !phase;
          if (mode == 3'd3) begin cnt++; par = par ^ d; end
          expb = d;
        end
      end
    end
    go = 1'b0; ent_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    chk(seeded === 1'b0 && rnd_valid === 1'b0, "R6 reset state", {seeded, rnd_valid}, 0);

    // R1 R2: 128-bit user seed, register-only stream
    for (int k = 0; k < 8; k++) sw[k] = 16'h1357 * 16'(k + 3) ^ 16'hA5C3;
    load_user(8, 1, "R2 128-bit seed loaded");
    run(300, 3'd0, 0, "R1 len128 stream");

    // R1 R2 R11: switch to 59 bits, top bits 63:59 of the seed dropped
    len_sel = 1'b0;
    idle(2);
    chk(seeded === 1'b0, "R11 len change clears seeded", seeded, 0);
    sw[0] = 16'hBEEF; sw[1] = 16'h0F0F; sw[2] = 16'h1234; sw[3] = 16'hFFFF;
    load_user(4, 1, "R2 59-bit seed loaded");
    run(300, 3'd0, 0, "R1 len59 stream");
    run(60, 3'd6, 0, "R7 reserved mode");

    // R10: user seed, modes 1 and 2 equal mode 0
    sw[0] = 16'h4321; sw[1] = 16'h8765; sw[2] = 16'hCBA9; sw[3] = 16'h0FED;
    load_user(4, 0, "R2 reseed");
    run(120, 3'd0, 0, "R10 base");
    nref = ncap;
    for (int k = 0; k < nref; k++) refb[k] = cap[k];
    for (int md = 1; md <= 2; md++) begin
      load_user(4, 0, "R2 reseed");
      run(120, 3'(md), 50, "R10 user mode");
      chk(ncap == nref, "R10 stream length", 128'(ncap), 128'(nref));
      for (int k = 0; k < nref; k++)
        if (cap[k] != refb[k]) chk(0, "R10 stream equal", 128'(cap[k]), 128'(refb[k]));
      chk(1, "R10 compare", 0, 0);
    end

    // R9 R10: parity mode with user seed
    load_user(4, 0, "R2 reseed");
    run(95, 3'd3, 30, "R9 user parity");

    // R5: masked-zero seed becomes 1
    sw[0] = 16'h0; sw[1] = 16'h0; sw[2] = 16'h0; sw[3] = 16'hF800;
    load_user(4, 0, "R5 zero seed load");
    chk(ms == 128'd1, "R5 model", ms, 1);
    run(100, 3'd0, 0, "R5 zero seed stream");

    // R3: pointer reset on length change
    len_sel = 1'b1;
    idle(1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); seed_we = 1'b1; seed_word = 16'hDEAD;
    end
    @(negedge clk); seed_we = 1'b0;
    len_sel = 1'b0;
    idle(2);
    sw[0] = 16'h2468; sw[1] = 16'hACE0; sw[2] = 16'h1111; sw[3] = 16'h0777;
    load_user(4, 1, "R3 seed after ptr reset");
    run(120, 3'd0, 0, "R3 stream after ptr reset");

    // R4: entropy seed, 128 bits; user writes ignored afterwards
    seed_src = 1'b0; len_sel = 1'b1;
    idle(2);
    chk(seeded === 1'b0, "R11 source change clears seeded", seeded, 0);
    feed_entropy(128);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); seed_we = 1'b1; seed_word = 16'hFFFF;
    end
    @(negedge clk); seed_we = 1'b0;
    run(200, 3'd1, 30, "R7 xor entropy");
    run(100, 3'd0, 0, "R3 writes ignored stream");

    // R8 R9 R7: 59-bit entropy seed, mixing modes
    len_sel = 1'b0;
    idle(2);
    feed_entropy(59);
    run(200, 3'd2, 30, "R8 cyclic");
    run(190, 3'd3, 20, "R9 cyclic parity");
    run(120, 3'd4, 40, "R7 entropy only");

    // R11: configuration change under go
    @(negedge clk); out_mode = 3'd0; go = 1'b1;
    @(negedge clk);
    chk(rnd_valid === 1'b1 && rnd_bit === ms[0], "R11 step before change", {rnd_valid, rnd_bit}, {1'b1, ms[0]});
    len_sel = 1'b1;
    @(negedge clk);
    chk(rnd_valid === 1'b0, "R11 no step on change", rnd_valid, 0);
    @(negedge clk);
    chk(seeded === 1'b0 && rnd_valid === 1'b0, "R11 dropped seed", {seeded, rnd_valid}, 0);
    go = 1'b0;
    idle(3);
    chk(rnd_valid === 1'b0, "R11 idle quiet", rnd_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule